// File: doc/BRIEF.md
# Single-Stage Sample Trigger Matcher

This block watches a stream of 34-channel logic samples and reports the moment a programmed trigger condition is met. Each channel can be left out of the condition or required to be high, low, rising or falling. A separate external trigger line can also take part, on its rising edge, its falling edge or either edge. Samples count only on cycles where the sample-enable strobe is high.

Software loads three 64-bit configuration words: a mask, a value and an edge select, with one bit per channel. When `arm` is pulsed, the block captures these words. It then evaluates every accepted sample until all selected conditions hold on the same sample. At that point it emits a one-cycle trigger pulse and disarms. A new `arm` pulse is needed before it can fire again.

Top module: `trigger_matcher`

## Requirements
- R1: While reset is asserted, and after it is released, `trig_pulse` is low. Before the first `arm` pulse, no sample produces a pulse.
- R2: The mask, value and edge words are captured in the cycle where `arm` is high. Changes to `cfg_mask`, `cfg_value` or `cfg_edge` after that cycle have no effect until the next `arm` pulse.
- R3: A channel with mask bit 1 and edge bit 0 is a level condition. It holds when the current sample bit equals the value bit: value 1 means high, value 0 means low.
- R4: A channel with mask bit 1 and edge bit 1 is an edge condition. It holds when the previously accepted sample bit differs from the value bit and the current sample bit equals it. Value 1 therefore means a rising edge and value 0 a falling edge.
- R5: The trigger requires every masked condition to hold on the same accepted sample. The following bits are ignored: channels with mask bit 0, all config bits at positions 36 and above, and value and edge bits 34 and 35. If mask bits 0 to 35 are all zero, the first accepted sample after arming fires.
- R6: Mask bit 35 requires a rising edge on `ext_trig`, and mask bit 34 requires a falling edge. When both bits are set, either edge satisfies the external condition. `ext_trig` is sampled only on accepted samples.
- R7: A sample is accepted only on a cycle where `smp_valid` is high. The stored previous sample, for both the channels and `ext_trig`, changes only on such cycles.
- R8: Edge conditions, on channels or on the external line, never hold on the first accepted sample after arming.
- R9: `trig_pulse` is high for exactly one cycle, in the cycle after the clock edge that accepts the qualifying sample. The block is then disarmed, and later samples do not fire until the next `arm` pulse.
- R10: A sample presented in the same cycle as `arm` is not evaluated. It is still taken as the previous sample if `smp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Captures the configuration and starts a new trigger search |
| cfg_mask | input | 64 | Per-channel enable bits; bits 34 and 35 select the external edges |
| cfg_value | input | 64 | Required level or edge direction per channel |
| cfg_edge | input | 64 | Per-channel selection of edge (1) or level (0) |
| smp_valid | input | 1 | Marks the cycle's sample as accepted |
| smp_data | input | 34 | Channel sample |
| ext_trig | input | 1 | External trigger line |
| trig_pulse | output | 1 | One-cycle trigger indication |

## Verification
A wrong previous-sample register shows up at the ports as a missed or spurious edge trigger, on the first accepted sample that follows the corruption. A stale first-sample flag makes an edge trigger fire on the very first accepted sample after `arm`, which the edge-only configurations expose within one sample. A wrong armed state shows up either as a second pulse in the cycle after a trigger, or as a silent sample where a zero-mask configuration must fire. Either way it becomes visible one cycle after the offending sample.

// File: rtl/trig_pkg.sv
package trig_pkg;

  // Condition of a single channel; unmasked channels always hold.
  function automatic logic chan_cond(input logic m, input logic v, input logic e,
                                     input logic cur, input logic prev, input logic first);
    logic lvl;
    logic edg;
    lvl = (cur == v);
    edg = !first && (prev != v) && (cur == v);
    return !m || (e ? edg : lvl);
  endfunction

  // External line: rise_en / fall_en select edges, either edge when both set.
  function automatic logic ext_cond(input logic rise_en, input logic fall_en,
                                    input logic cur, input logic prev, input logic first);
    logic rise;
    logic fall;
    rise = !prev && cur;
    fall = prev && !cur;
    if (!rise_en && !fall_en) return 1'b1;
    return !first && ((rise_en && rise) || (fall_en && fall));
  endfunction

endpackage

// File: rtl/trig_cfg_store.sv
module trig_cfg_store #(
  parameter int CFG_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] mask_i,
  input  logic [CFG_W-1:0] value_i,
  input  logic [CFG_W-1:0] edge_i,
  output logic [CFG_W-1:0] mask_o,
  output logic [CFG_W-1:0] value_o,
  output logic [CFG_W-1:0] edge_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o  <= '0;
      value_o <= '0;
      edge_o  <= '0;
    end else if (load) begin
      mask_o  <= mask_i;
      value_o <= value_i;
      edge_o  <= edge_i;
    end
  end

endmodule

// File: rtl/trig_history.sv
module trig_history #(
  parameter int NUM_CH = 34
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              smp_valid,
  input  logic [NUM_CH-1:0] smp_data,
  input  logic              ext_in,
  output logic [NUM_CH-1:0] prev_data,
  output logic              prev_ext,
  output logic              first
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_data <= '0;
      prev_ext  <= 1'b0;
    end else if (smp_valid) begin
      prev_data <= smp_data;
      prev_ext  <= ext_in;
    end
  end

  // First accepted sample after arming is flagged.
  always_ff @(posedge clk) begin
    if (!rst_n)         first <= 1'b1;
    else if (arm)       first <= 1'b1;
    else if (smp_valid) first <= 1'b0;
  end

endmodule

// File: rtl/trig_eval.sv
module trig_eval
  import trig_pkg::*;
#(
  parameter int NUM_CH       = 34,
  parameter int CFG_W        = 64,
  parameter int EXT_FALL_BIT = 34,
  parameter int EXT_RISE_BIT = 35
) (
  input  logic [CFG_W-1:0]  mask,
  input  logic [CFG_W-1:0]  value,
  input  logic [CFG_W-1:0]  edge_sel,
  input  logic [NUM_CH-1:0] cur,
  input  logic [NUM_CH-1:0] prev,
  input  logic              cur_ext,
  input  logic              prev_ext,
  input  logic              first,
  output logic [NUM_CH-1:0] chan_ok,
  output logic              ext_ok,
  output logic              all_ok
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign chan_ok[i] = chan_cond(mask[i], value[i], edge_sel[i], cur[i], prev[i], first);
  end

  assign ext_ok = ext_cond(mask[EXT_RISE_BIT], mask[EXT_FALL_BIT], cur_ext, prev_ext, first);
  assign all_ok = (&chan_ok) && ext_ok;

endmodule

// File: rtl/trigger_matcher.sv
module trigger_matcher #(
  parameter int NUM_CH = 34,
  parameter int CFG_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic [CFG_W-1:0]  cfg_mask,
  input  logic [CFG_W-1:0]  cfg_value,
  input  logic [CFG_W-1:0]  cfg_edge,
  input  logic              smp_valid,
  input  logic [NUM_CH-1:0] smp_data,
  input  logic              ext_trig,
  output logic              trig_pulse
);

  localparam int EXT_FALL_BIT = NUM_CH;
  localparam int EXT_RISE_BIT = NUM_CH + 1;

  logic [CFG_W-1:0]  mask_q, value_q, edge_q;
  logic [NUM_CH-1:0] prev_data;
  logic [NUM_CH-1:0] chan_ok;
  logic              prev_ext, first_q, ext_ok, all_ok;
  logic              armed_q;
  logic              hit;
  logic              mask_zero;

  trig_cfg_store #(.CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(arm),
    .mask_i(cfg_mask), .value_i(cfg_value), .edge_i(cfg_edge),
    .mask_o(mask_q), .value_o(value_q), .edge_o(edge_q)
  );

  trig_history #(.NUM_CH(NUM_CH)) u_hist (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid),
    .smp_data(smp_data), .ext_in(ext_trig),
    .prev_data(prev_data), .prev_ext(prev_ext), .first(first_q)
  );

  trig_eval #(
    .NUM_CH(NUM_CH), .CFG_W(CFG_W),
    .EXT_FALL_BIT(EXT_FALL_BIT), .EXT_RISE_BIT(EXT_RISE_BIT)
  ) u_eval (
    .mask(mask_q), .value(value_q), .edge_sel(edge_q),
    .cur(smp_data), .prev(prev_data), .cur_ext(ext_trig), .prev_ext(prev_ext),
    .first(first_q), .chan_ok(chan_ok), .ext_ok(ext_ok), .all_ok(all_ok)
  );

  // Named event for the checker: no condition bit selected at all.
  assign mask_zero = (mask_q[EXT_RISE_BIT:0] == '0);

  assign hit = armed_q && smp_valid && !arm && all_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)   armed_q <= 1'b0;
    else if (arm) armed_q <= 1'b1;
    else if (hit) armed_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trig_pulse <= 1'b0;
    else        trig_pulse <= hit;
  end

endmodule

// File: rtl/trigger_matcher_chk.sv
module trigger_matcher_chk #(
  parameter int NUM_CH = 34
) (
  input logic              clk,
  input logic              rst_n,
  input logic              arm,
  input logic              smp_valid,
  input logic              trig_pulse,
  input logic              armed_q,
  input logic              first_q,
  input logic              mask_zero,
  input logic [NUM_CH-1:0] prev_data
);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  // R9
  disarm_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && !$past(arm)) |-> !armed_q);

  // R7
  prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(prev_data));

  // R8
  first_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(first_q) |-> $past(smp_valid));

  // R5
  zero_mask_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && smp_valid && !arm && mask_zero) |=> trig_pulse);

  // R1
  pulse_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> $past(armed_q && smp_valid));

endmodule

bind trigger_matcher trigger_matcher_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .smp_valid(smp_valid),
  .trig_pulse(trig_pulse), .armed_q(armed_q), .first_q(first_q),
  .mask_zero(mask_zero), .prev_data(prev_data)
);

// File: tb/trigger_matcher_tb.sv
module trigger_matcher_tb;

  localparam int NCH = 34;
  localparam int ROWS = 20;
  // row: [43:40] req, [39:38] cfg, [37] arm, [36] valid, [35] ext, [34:1] data, [0] exp
  localparam logic [43:0] TBL [ROWS] = '{
    {4'd10, 2'd0, 1'b1, 1'b1, 1'b0, 34'h1,         1'b0}, // R10 arm-cycle sample ignored
    {4'd3,  2'd0, 1'b0, 1'b1, 1'b0, 34'h0,         1'b0}, // R3 ch0 low, needs high
    {4'd3,  2'd0, 1'b0, 1'b1, 1'b0, 34'h3,         1'b0}, // R3 ch1 high, needs low
    {4'd7,  2'd0, 1'b0, 1'b0, 1'b0, 34'h1,         1'b0}, // R7 not accepted
    {4'd3,  2'd0, 1'b0, 1'b1, 1'b0, 34'h1,         1'b1}, // R3 match
    {4'd9,  2'd0, 1'b0, 1'b1, 1'b0, 34'h1,         1'b0}, // R9 disarmed
    {4'd10, 2'd1, 1'b1, 1'b0, 1'b0, 34'h0,         1'b0}, // R10
    {4'd8,  2'd1, 1'b0, 1'b1, 1'b0, 34'h4,         1'b0}, // R8 first sample
    {4'd4,  2'd1, 1'b0, 1'b1, 1'b0, 34'h4,         1'b0}, // R4 stays high
    {4'd4,  2'd1, 1'b0, 1'b1, 1'b0, 34'h0,         1'b0}, // R4 falls
    {4'd7,  2'd1, 1'b0, 1'b0, 1'b0, 34'h4,         1'b0}, // R7 prev kept
    {4'd4,  2'd1, 1'b0, 1'b1, 1'b0, 34'h4,         1'b1}, // R4 rising
    {4'd10, 2'd2, 1'b1, 1'b0, 1'b0, 34'h0,         1'b0}, // R10
    {4'd8,  2'd2, 1'b0, 1'b1, 1'b0, 34'h2_0000_0000, 1'b0}, // R8
    {4'd5,  2'd2, 1'b0, 1'b1, 1'b0, 34'h0F,        1'b1}, // R5 falling ch33, others free
    {4'd10, 2'd3, 1'b1, 1'b0, 1'b0, 34'h0,         1'b0}, // R10
    {4'd8,  2'd3, 1'b0, 1'b1, 1'b1, 34'h0,         1'b0}, // R8 ext first
    {4'd6,  2'd3, 1'b0, 1'b1, 1'b0, 34'h0,         1'b0}, // R6 ext falls
    {4'd7,  2'd3, 1'b0, 1'b0, 1'b1, 34'h0,         1'b0}, // R7 ext not accepted
    {4'd6,  2'd3, 1'b0, 1'b1, 1'b1, 34'h0,         1'b1}  // R6 ext rises
  };

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           arm = 1'b0;
  logic [63:0]    cfg_mask = '0, cfg_value = '0, cfg_edge = '0;
  logic           smp_valid = 1'b0;
  logic [NCH-1:0] smp_data = '0;
  logic           ext_trig = 1'b0;
  logic           trig_pulse;
  int             n_cmp = 0;
  int             n_bad = 0;

  always #5 clk = ~clk;

  trigger_matcher u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_mask(cfg_mask),
    .cfg_value(cfg_value), .cfg_edge(cfg_edge), .smp_valid(smp_valid),
    .smp_data(smp_data), .ext_trig(ext_trig), .trig_pulse(trig_pulse)
  );

  function automatic string req_name(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic exp);
    n_cmp++;
    if (trig_pulse !== exp) begin
      n_bad++;
      $display("FAIL %s: trig_pulse=%b expected=%b at %0t", req, trig_pulse, exp, $time);
    end
  endtask

  task automatic apply_cfg(input int sel);
    case (sel)
      0: begin cfg_mask = 64'h3; cfg_value = 64'h1; cfg_edge = 64'h0; end
      1: begin cfg_mask = 64'h4; cfg_value = 64'h4; cfg_edge = 64'h4; end
      2: begin cfg_mask = 64'h1 << 33; cfg_value = 64'h0; cfg_edge = 64'h1 << 33; end
      default: begin cfg_mask = 64'h1 << 35; cfg_value = 64'h0; cfg_edge = 64'h0; end
    endcase
  endtask

  // Drive at a falling edge, let one rising edge pass, then check.
  task automatic step(input logic a, input logic v, input logic e,
                      input logic [NCH-1:0] d, input string req, input logic exp);
    arm = a; smp_valid = v; ext_trig = e; smp_data = d;
    @(negedge clk);
    check(req, exp);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
  end

  initial begin
    @(negedge clk);
    smp_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);               // R1 during reset
    rst_n = 1'b1;
    step(0, 1, 0, '0, "R1", 1'b0);   // R1 not armed yet
    step(0, 1, 1, '1, "R1", 1'b0);

    for (int i = 0; i < ROWS; i++) begin
      apply_cfg(int'(TBL[i][39:38]));
      step(TBL[i][37], TBL[i][36], TBL[i][35], TBL[i][34:1],
           req_name(int'(TBL[i][43:40])), TBL[i][0]);
    end

    // R5 zero mask fires on first accepted sample; R9 only one cycle
    cfg_mask = '0; cfg_value = '1; cfg_edge = '1;
    step(1, 0, 0, '0, "R10", 1'b0);
    step(0, 1, 0, '0, "R5", 1'b1);
    step(0, 1, 0, '0, "R9", 1'b0);

    // R5 mask bits above 35 are ignored
    cfg_mask = 64'h1 << 40;
    step(1, 0, 0, '0, "R10", 1'b0);
    step(0, 1, 0, '1, "R5", 1'b1);

    // R2 config captured at arm, later input changes ignored
    apply_cfg(0);
    step(1, 0, 0, '0, "R10", 1'b0);
    cfg_mask = '0;
    step(0, 1, 0, '0, "R2", 1'b0);
    step(0, 1, 0, 34'h1, "R2", 1'b1);

    // R6 falling external edge via bit 34
    cfg_mask = 64'h1 << 34;
    step(1, 0, 1, '0, "R10", 1'b0);
    step(0, 1, 1, '0, "R8", 1'b0);
    step(0, 1, 0, '0, "R6", 1'b1);

    // R6 both bits: either edge
    cfg_mask = 64'h3 << 34;
    step(1, 0, 0, '0, "R10", 1'b0);
    step(0, 1, 0, '0, "R6", 1'b0);
    step(0, 1, 1, '0, "R6", 1'b1);

    // R9 re-arm enables firing again
    cfg_mask = '0;
    step(1, 0, 0, '0, "R10", 1'b0);
    step(0, 1, 0, '0, "R9", 1'b1);

    summary();
  end

endmodule